// File: doc/BRIEF.md
# Key-Unlocked RAM Wipe Controller

This block lets software clear two on-chip RAMs in hardware: a protected scratch RAM and the working RAM of a crypto accelerator. The clear cannot be started by accident. Software must first write an exact two-value key to an 8-bit key field. Only then does a write of 1 to the wipe-request bit in the control/status register start the erase. The erase engine then steps one address counter over both arrays and writes a zero word to each RAM on every clock. While it runs, it blocks ordinary bus writes to either RAM.

The control/status register also holds a sticky fetch-block bit for the second CPU. Software can set this bit, but only a hardware reset clears it. While it is set, any instruction fetch that the second CPU makes from the SRAM regions is answered with a bus error.

A control module holds the key state machine, the request bit, the sticky bit and the register read mux. A datapath module holds the wipe counter and one write-port mux per RAM. The control starts the datapath through a one-strobe command struct. The datapath reports back its running and final-beat flags.

Top module: `ram_wipe_top`

## Requirements
- R1: After reset, the control/status register reads 0x0000_0000, neither RAM write enable is active, and neither stall output is high.
- R2: A key-field write of 0xCA, then a key-field write of 0x53, then a control/status write with bit 0 set starts a wipe. Busy (bit 1) and request (bit 0) read 1 on the cycle after that write.
- R3: A control/status write with bit 0 set is ignored when the key is not unlocked: no RAM is written and bits 1:0 stay 0.
- R4: Any key value other than 0x53 written after 0xCA re-locks the key. A lone 0x53 never unlocks.
- R5: When 0xCA is written twice in a row, the second 0xCA counts as the first step of a new sequence, so 0xCA, 0xCA, 0x53 unlocks.
- R6: During a wipe, each RAM receives zero-data writes to addresses 0 up to its depth minus 1, in ascending order, one per clock, starting on the cycle after the start. No other writes reach either RAM.
- R7: Bits 1 and 0 stay high for exactly as many cycles as the deeper RAM has words, then both clear together.
- R8: Starting a wipe consumes the unlock. A further bit 0 write without a new key sequence is ignored.
- R9: While a wipe is busy, both stall outputs are high and bus write requests do not reach either RAM. When idle, a bus write passes straight to its RAM in the same cycle with the stall low.
- R10: Writing 1 to bit 31 of the control/status register sets the fetch-block bit. A later write of 0 leaves it set, and only reset clears it.
- R11: A bus error is flagged for a second-CPU fetch exactly when the fetch is valid, targets SRAM, and the fetch-block bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register word address (read and write) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| fetchValid | input | 1 | Second-CPU instruction fetch valid |
| fetchInSram | input | 1 | Fetch address falls in an SRAM region |
| fetchErr | output | 1 | Bus error for the current fetch |
| aWrReq | input | 1 | Bus write request, scratch RAM |
| aWrAddr | input | A_AW | Bus write address, scratch RAM |
| aWrData | input | DATA_W | Bus write data, scratch RAM |
| aWrStall | output | 1 | Scratch RAM bus write stalled |
| aMemWe | output | 1 | Scratch RAM write enable |
| aMemAddr | output | A_AW | Scratch RAM write address |
| aMemWdata | output | DATA_W | Scratch RAM write data |
| bWrReq | input | 1 | Bus write request, accelerator RAM |
| bWrAddr | input | B_AW | Bus write address, accelerator RAM |
| bWrData | input | DATA_W | Bus write data, accelerator RAM |
| bWrStall | output | 1 | Accelerator RAM bus write stalled |
| bMemWe | output | 1 | Accelerator RAM write enable |
| bMemAddr | output | B_AW | Accelerator RAM write address |
| bMemWdata | output | DATA_W | Accelerator RAM write data |

## Verification
The assertions assume that a bus master whose write is stalled keeps its request pending and does not count it as done. They also assume that reset is the only path that clears the fetch-block bit. The bench raises bus write requests during a wipe only to observe the stall, and drops them before the wipe ends, so no stalled write is ever replayed. All register and bus inputs change one time unit after a rising edge, and results are sampled at the falling edge.

// File: rtl/ram_wipe_pkg.sv
package ram_wipe_pkg;

  // key values, in the order they must arrive
  localparam logic [7:0] KEY_STEP1 = 8'hCA;
  localparam logic [7:0] KEY_STEP2 = 8'h53;

  // control/status bit positions (software-visible encoding)
  localparam int REQ_BIT  = 0;
  localparam int BUSY_BIT = 1;
  localparam int FDIS_BIT = 31;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_ARMED  = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic start;
  } wipeCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic active;
    logic lastBeat;
  } wipeStat_t;

endpackage

// File: rtl/ram_wipe_ctrl.sv
module ram_wipe_ctrl
  import ram_wipe_pkg::*;
#(
  parameter int            REG_AW  = 4,
  parameter logic [REG_AW-1:0] KEY_OFS = 4'h9,
  parameter logic [REG_AW-1:0] CSR_OFS = 4'h6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              fetchValid,
  input  logic              fetchInSram,
  output logic              fetchErr,
  input  wipeStat_t         stat,
  output wipeCmd_t          cmd,
  output logic              reqBit,
  output logic              fetchDis,
  output logic              keyOpen
);

  keyState_t keyState, keyNext;
  logic      keyWr, csrWr, startNow;

  assign keyWr    = regWrEn && (regAddr == KEY_OFS);
  assign csrWr    = regWrEn && (regAddr == CSR_OFS);
  assign keyOpen  = (keyState == KEY_OPEN);
  assign startNow = csrWr && regWrData[REQ_BIT] && keyOpen && !stat.active;
  assign cmd.start = startNow;

  // key sequencer: a leading value always re-arms, anything else out of order locks
  always_comb begin
    keyNext = keyState;
    if (startNow) begin
      keyNext = KEY_LOCKED;
    end else if (keyWr) begin
      if (regWrData[7:0] == KEY_STEP1)
        keyNext = KEY_ARMED;
      else if ((keyState == KEY_ARMED) && (regWrData[7:0] == KEY_STEP2))
        keyNext = KEY_OPEN;
      else
        keyNext = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_LOCKED;
      reqBit   <= 1'b0;
      fetchDis <= 1'b0;
    end else begin
      keyState <= keyNext;
      if (startNow)
        reqBit <= 1'b1;
      else if (stat.lastBeat)
        reqBit <= 1'b0;
      if (csrWr && regWrData[FDIS_BIT])
        fetchDis <= 1'b1;
    end
  end

  assign fetchErr = fetchValid && fetchInSram && fetchDis;

  // key field is write-only and reads as zero
  always_comb begin
    regRdData = '0;
    if (regAddr == CSR_OFS) begin
      regRdData[FDIS_BIT] = fetchDis;
      regRdData[BUSY_BIT] = stat.active;
      regRdData[REQ_BIT]  = reqBit;
    end
  end

endmodule

// File: rtl/ram_wipe_port.sv
module ram_wipe_port #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              active,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              busReq,
  input  logic [AW-1:0]     busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              busStall,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(DEPTH);

  logic inRange;
  assign inRange  = ({1'b0, cnt} < LIMIT);
  assign busStall = active;

  always_comb begin
    if (active) begin
      memWe    = inRange;
      memAddr  = cnt[AW-1:0];
      memWdata = '0;
    end else begin
      memWe    = busReq;
      memAddr  = busAddr;
      memWdata = busData;
    end
  end

endmodule

// File: rtl/ram_wipe_dp.sv
module ram_wipe_dp
  import ram_wipe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int A_DEPTH = 64,
  parameter int B_DEPTH = 32,
  parameter int A_AW    = 6,
  parameter int B_AW    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  wipeCmd_t          cmd,
  output wipeStat_t         stat,
  input  logic              aWrReq,
  input  logic [A_AW-1:0]   aWrAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic              aWrStall,
  output logic              aMemWe,
  output logic [A_AW-1:0]   aMemAddr,
  output logic [DATA_W-1:0] aMemWdata,
  input  logic              bWrReq,
  input  logic [B_AW-1:0]   bWrAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic              bWrStall,
  output logic              bMemWe,
  output logic [B_AW-1:0]   bMemAddr,
  output logic [DATA_W-1:0] bMemWdata
);

  localparam int MAX_DEPTH = (A_DEPTH > B_DEPTH) ? A_DEPTH : B_DEPTH;
  localparam int CNT_W     = $clog2(MAX_DEPTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_DEPTH - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;

  assign stat.active   = active;
  assign stat.lastBeat = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cmd.start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  ram_wipe_port #(.DEPTH(A_DEPTH), .AW(A_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_portA (
    .active(active), .cnt(cnt),
    .busReq(aWrReq), .busAddr(aWrAddr), .busData(aWrData), .busStall(aWrStall),
    .memWe(aMemWe), .memAddr(aMemAddr), .memWdata(aMemWdata)
  );

  ram_wipe_port #(.DEPTH(B_DEPTH), .AW(B_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_portB (
    .active(active), .cnt(cnt),
    .busReq(bWrReq), .busAddr(bWrAddr), .busData(bWrData), .busStall(bWrStall),
    .memWe(bMemWe), .memAddr(bMemAddr), .memWdata(bMemWdata)
  );

endmodule

// File: rtl/ram_wipe_top.sv
module ram_wipe_top
  import ram_wipe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int A_DEPTH = 64,
  parameter int B_DEPTH = 32,
  parameter int REG_AW  = 4,
  parameter logic [REG_AW-1:0] KEY_OFS = 4'h9,
  parameter logic [REG_AW-1:0] CSR_OFS = 4'h6,
  localparam int A_AW = $clog2(A_DEPTH),
  localparam int B_AW = $clog2(B_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              fetchValid,
  input  logic              fetchInSram,
  output logic              fetchErr,
  input  logic              aWrReq,
  input  logic [A_AW-1:0]   aWrAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic              aWrStall,
  output logic              aMemWe,
  output logic [A_AW-1:0]   aMemAddr,
  output logic [DATA_W-1:0] aMemWdata,
  input  logic              bWrReq,
  input  logic [B_AW-1:0]   bWrAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic              bWrStall,
  output logic              bMemWe,
  output logic [B_AW-1:0]   bMemAddr,
  output logic [DATA_W-1:0] bMemWdata
);

  wipeCmd_t  cmd;
  wipeStat_t stat;
  logic      reqBit, fetchDis, keyOpen, busy;

  assign busy = stat.active;

  ram_wipe_ctrl #(.REG_AW(REG_AW), .KEY_OFS(KEY_OFS), .CSR_OFS(CSR_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fetchValid(fetchValid), .fetchInSram(fetchInSram), .fetchErr(fetchErr),
    .stat(stat), .cmd(cmd), .reqBit(reqBit), .fetchDis(fetchDis), .keyOpen(keyOpen)
  );

  ram_wipe_dp #(.DATA_W(DATA_W), .A_DEPTH(A_DEPTH), .B_DEPTH(B_DEPTH),
                .A_AW(A_AW), .B_AW(B_AW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat),
    .aWrReq(aWrReq), .aWrAddr(aWrAddr), .aWrData(aWrData), .aWrStall(aWrStall),
    .aMemWe(aMemWe), .aMemAddr(aMemAddr), .aMemWdata(aMemWdata),
    .bWrReq(bWrReq), .bWrAddr(bWrAddr), .bWrData(bWrData), .bWrStall(bWrStall),
    .bMemWe(bMemWe), .bMemAddr(bMemAddr), .bMemWdata(bMemWdata)
  );

endmodule

// File: rtl/ram_wipe_chk.sv
module ram_wipe_chk #(
  parameter int DATA_W = 32,
  parameter int A_AW   = 6,
  parameter int B_AW   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              keyOpen,
  input logic              busy,
  input logic              reqBit,
  input logic              fetchDis,
  input logic              aMemWe,
  input logic [A_AW-1:0]   aMemAddr,
  input logic [DATA_W-1:0] aMemWdata,
  input logic              bMemWe,
  input logic [DATA_W-1:0] bMemWdata
);

  // R3: a wipe only begins from the unlocked key state
  assert_start_needs_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(keyOpen));

  // R8: the unlock is spent by the start
  assert_unlock_consumed_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !keyOpen);

  // R7: request bit and busy flag move together
  assert_req_tracks_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqBit == busy);

  // R6: wipe writes carry zero data
  assert_zero_fill_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && aMemWe |-> aMemWdata == '0);
  assert_zero_fill_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && bMemWe |-> bMemWdata == '0);

  // R6: consecutive wipe writes step the address by one
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && aMemWe && $past(busy) && $past(aMemWe) |-> aMemAddr == A_AW'($past(aMemAddr) + 1'b1));

  // R10: fetch-block bit is sticky until reset
  assert_fetch_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    fetchDis |=> fetchDis);

endmodule

bind ram_wipe_top ram_wipe_chk #(.DATA_W(DATA_W), .A_AW(A_AW), .B_AW(B_AW)) u_chk (
  .clk(clk), .rstN(rstN), .keyOpen(keyOpen), .busy(busy), .reqBit(reqBit),
  .fetchDis(fetchDis), .aMemWe(aMemWe), .aMemAddr(aMemAddr), .aMemWdata(aMemWdata),
  .bMemWe(bMemWe), .bMemWdata(bMemWdata)
);

// File: tb/ram_wipe_top_test.sv
module ram_wipe_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 32;
  localparam int A_DEPTH = 64;
  localparam int B_DEPTH = 32;
  localparam int A_AW    = 6;
  localparam int B_AW    = 5;
  localparam logic [3:0] KEY = 4'h9;
  localparam logic [3:0] CSR = 4'h6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [3:0]        regAddr = CSR;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              fetchValid = 1'b0, fetchInSram = 1'b0, fetchErr;
  logic              aWrReq = 1'b0, bWrReq = 1'b0;
  logic [A_AW-1:0]   aWrAddr = '0, aMemAddr;
  logic [B_AW-1:0]   bWrAddr = '0, bMemAddr;
  logic [DATA_W-1:0] aWrData = '0, bWrData = '0, aMemWdata, bMemWdata;
  logic              aWrStall, bWrStall, aMemWe, bMemWe;

  int  nChecks = 0, nFails = 0;
  bit  finished = 1'b0;
  logic [39:0] qA[$];
  logic [39:0] qB[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_wipe_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .fetchValid(fetchValid), .fetchInSram(fetchInSram), .fetchErr(fetchErr),
    .aWrReq(aWrReq), .aWrAddr(aWrAddr), .aWrData(aWrData), .aWrStall(aWrStall),
    .aMemWe(aMemWe), .aMemAddr(aMemAddr), .aMemWdata(aMemWdata),
    .bWrReq(bWrReq), .bWrAddr(bWrAddr), .bWrData(bWrData), .bWrStall(bWrStall),
    .bMemWe(bMemWe), .bMemAddr(bMemAddr), .bMemWdata(bMemWdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every RAM write must match the head of its expectation queue
  always @(negedge clk) if (rstN) begin
    if (aMemWe) begin
      if (qA.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R6 unexpected RAM A write actual=%h expected=none", aMemAddr);
      end else begin
        logic [39:0] itA;
        itA = qA.pop_front();
        check("R6 RAM A addr", 32'(aMemAddr), 32'(itA[39:32]));
        check("R6 RAM A data", aMemWdata, itA[31:0]);
      end
    end
    if (bMemWe) begin
      if (qB.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R6 unexpected RAM B write actual=%h expected=none", bMemAddr);
      end else begin
        logic [39:0] itB;
        itB = qB.pop_front();
        check("R6 RAM B addr", 32'(bMemAddr), 32'(itB[39:32]));
        check("R6 RAM B data", bMemWdata, itB[31:0]);
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = CSR; regWrData = '0;
  endtask

  task automatic rdCsr(output logic [31:0] v);
    @(posedge clk); #1;
    regAddr = CSR;
    #1 v = regRdData;
  endtask

  task automatic expectWipe();
    for (int i = 0; i < A_DEPTH; i++) qA.push_back({8'(i), 32'h0});
    for (int i = 0; i < B_DEPTH; i++) qB.push_back({8'(i), 32'h0});
  endtask

  // run a started wipe to completion, checking stall and busy length
  task automatic runWipe(string tag);
    int busyCnt;
    int reqCnt;
    busyCnt = 0; reqCnt = 0;
    aWrReq = 1'b1; aWrAddr = 6'd3; aWrData = 32'hDEAD_BEEF;
    bWrReq = 1'b1; bWrAddr = 5'd4; bWrData = 32'hFEED_F00D;
    @(negedge clk);
    check("R9 A stall while busy", 32'(aWrStall), 32'd1);
    check("R9 B stall while busy", 32'(bWrStall), 32'd1);
    check({tag, " busy/req after start"}, regRdData & 32'h3, 32'h3);
    busyCnt += regRdData[1]; reqCnt += regRdData[0];
    @(posedge clk); #1;
    aWrReq = 1'b0; bWrReq = 1'b0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (!regRdData[1] && !regRdData[0]) break;
      busyCnt += regRdData[1]; reqCnt += regRdData[0];
    end
    check("R7 busy cycles", 32'(busyCnt), 32'(A_DEPTH));
    check("R7 request cycles", 32'(reqCnt), 32'(A_DEPTH));
    check("R6 RAM A queue drained", 32'(qA.size()), 32'd0);
    check("R6 RAM B queue drained", 32'(qB.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdCsr(v);
    check("R1 csr after reset", v, 32'h0);
    @(negedge clk);
    check("R1 A we", 32'(aMemWe), 32'd0);
    check("R1 B we", 32'(bMemWe), 32'd0);
    check("R1 stall", 32'(aWrStall | bWrStall), 32'd0);

    // R3 request without key
    wr(CSR, 32'h1);
    rdCsr(v);
    check("R3 request without key", v & 32'h3, 32'h0);

    // R4 lone second value, and wrong value after first
    wr(KEY, 32'h53); wr(CSR, 32'h1);
    rdCsr(v);
    check("R4 lone 0x53", v & 32'h3, 32'h0);
    wr(KEY, 32'hCA); wr(KEY, 32'h11); wr(KEY, 32'h53); wr(CSR, 32'h1);
    rdCsr(v);
    check("R4 wrong middle key", v & 32'h3, 32'h0);

    // R2 correct pair starts a wipe
    wr(KEY, 32'hCA); wr(KEY, 32'h53);
    expectWipe();
    wr(CSR, 32'h1);
    runWipe("R2");

    // R8 unlock consumed
    wr(CSR, 32'h1);
    rdCsr(v);
    check("R8 second request without key", v & 32'h3, 32'h0);

    // R5 repeated first value
    wr(KEY, 32'hCA); wr(KEY, 32'hCA); wr(KEY, 32'h53);
    expectWipe();
    wr(CSR, 32'h1);
    runWipe("R5");

    // R9 idle pass-through
    qA.push_back({8'd5, 32'h1234_ABCD});
    qB.push_back({8'd7, 32'h0BAD_CAFE});
    @(posedge clk); #1;
    aWrReq = 1'b1; aWrAddr = 6'd5; aWrData = 32'h1234_ABCD;
    bWrReq = 1'b1; bWrAddr = 5'd7; bWrData = 32'h0BAD_CAFE;
    @(negedge clk);
    check("R9 idle A stall", 32'(aWrStall), 32'd0);
    check("R9 idle B stall", 32'(bWrStall), 32'd0);
    @(posedge clk); #1;
    aWrReq = 1'b0; bWrReq = 1'b0;
    @(negedge clk);
    check("R9 pass-through drained", 32'(qA.size() + qB.size()), 32'd0);

    // R11 / R10 fetch block
    @(posedge clk); #1;
    fetchValid = 1'b1; fetchInSram = 1'b1;
    @(negedge clk);
    check("R11 no error before set", 32'(fetchErr), 32'd0);
    wr(CSR, 32'h8000_0000);
    rdCsr(v);
    check("R10 bit31 set", v, 32'h8000_0000);
    @(negedge clk);
    check("R11 error when set", 32'(fetchErr), 32'd1);
    @(posedge clk); #1 fetchInSram = 1'b0;
    @(negedge clk);
    check("R11 no error outside SRAM", 32'(fetchErr), 32'd0);
    @(posedge clk); #1 fetchInSram = 1'b1; fetchValid = 1'b0;
    @(negedge clk);
    check("R11 no error without fetch", 32'(fetchErr), 32'd0);
    wr(CSR, 32'h0);
    rdCsr(v);
    check("R10 write of 0 ignored", v, 32'h8000_0000);
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    rdCsr(v);
    check("R10 cleared by reset", v, 32'h0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule